// File: doc/BRIEF.md
# Mirrored Memory Map Decoder

This block sits between an 8-bit processor's 16-bit address bus and three byte-wide targets: a 2 KiB work RAM, an eight-entry register window and a program ROM. Each request carries an address, a strobe and a read/write flag. In the same cycle, the block raises the select for the target that owns the address. It also folds the address down to the offset inside that target. Work RAM repeats every 2 KiB below 0x2000. The register window repeats every eight bytes between 0x2000 and 0x3FFF. The ROM occupies the top half of the map.

A static configuration input gives the ROM size. With a 32 KiB ROM the upper half maps straight through. With a 16 KiB ROM the same image appears twice, at 0x8000 and at 0xC000. The range 0x4000 to 0x7FFF belongs to no target.

The targets are synchronous memories that return read data on the clock edge after a select. The block records which target a read went to and steers that target's data bus onto a single return bus in the following cycle. Reads of unmapped space, writes and idle cycles return 0x00. Writes reach only the RAM and the register window. A write that decodes to the ROM produces no write enable, so the ROM image cannot change.

Top module: `mirror_map_dec`

## Requirements
- R1: With the strobe high, an address below 0x2000 raises `ram_sel`, and `phys_addr` equals address bits 10:0 with the upper bits zero.
- R2: With the strobe high, an address from 0x2000 to 0x3FFF raises `reg_sel`, and `phys_addr` equals address bits 2:0 with the upper bits zero.
- R3: With the strobe high, an address of 0x8000 or above raises `rom_sel`. With `rom_big` = 1 (32 KiB), `phys_addr` is the address minus 0x8000.
- R4: With `rom_big` = 0 (16 KiB), the ROM offset is (address minus 0x8000) modulo 0x4000, so 0x8000+n and 0xC000+n give the same offset.
- R5: A write (`wr` = 1) to RAM or to the register window raises `ram_we` or `reg_we` together with the select, using the same folded offset that a read of that address uses. Data written through one mirror reads back through another.
- R6: A write that decodes to ROM raises neither write enable. A later read of that ROM location returns the original byte.
- R7: An address from 0x4000 to 0x7FFF raises no select, drives `phys_addr` to 0, and a read there returns 0x00 on `rd_data` one cycle later.
- R8: At most one select is high at any time. With the strobe low, all selects and write enables are low.
- R9: One cycle after a read of RAM, the register window or ROM, `rd_data` equals that target's read-data bus. One cycle after a write or an idle cycle, `rd_data` is 0x00.
- R10: During and right after reset, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access strobe for this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Processor address |
| rom_big | input | 1 | ROM size: 1 = 32 KiB, 0 = 16 KiB |
| ram_sel | output | 1 | Work RAM select |
| reg_sel | output | 1 | Register window select |
| rom_sel | output | 1 | Program ROM select |
| ram_we | output | 1 | Work RAM write enable |
| reg_we | output | 1 | Register window write enable |
| phys_addr | output | 15 | Folded offset inside the selected target |
| ram_rdata | input | 8 | Registered read data from work RAM |
| reg_rdata | input | 8 | Registered read data from the register window |
| rom_rdata | input | 8 | Registered read data from ROM |
| rd_data | output | 8 | Read data returned to the processor |

## Verification
Selects, write enables and the folded offset are combinational, so they are due in the same cycle as the request. The bench drives each request on the falling edge and samples these outputs 1 ns later. Read data passes through the target's output register and the block's target register, so it is due right after the next rising edge. The bench samples `rd_data` 1 ns after that edge and before it drives the next request. The expected offset comes from arithmetic subtraction and modulo, not from bit slicing. The expected data comes from a shadow RAM and register file that the bench indexes with its own fold.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int ADDR_W = 16;
  localparam int RAM_AW = 11;
  localparam int REG_AW = 3;
  localparam int ROM_AW = 15;
  localparam int OFF_W  = ROM_AW;
  localparam int ROM_SMALL_AW = ROM_AW - 1;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_REG  = 2'd2,
    TGT_ROM  = 2'd3
  } mm_tgt_e;

  // Region decode by the top address bits: bit 15 marks ROM, bit 14 the hole,
  // bit 13 the register window, otherwise work RAM.
  function automatic mm_tgt_e region_of(input logic [ADDR_W-1:0] a);
    if (a[15])      return TGT_ROM;
    else if (a[14]) return TGT_NONE;
    else if (a[13]) return TGT_REG;
    else            return TGT_RAM;
  endfunction

  // Mirror fold: keep only the offset bits that the target decodes.
  function automatic logic [OFF_W-1:0] fold_off(input mm_tgt_e t,
                                               input logic [ADDR_W-1:0] a,
                                               input logic big);
    logic [OFF_W-1:0] o;
    o = '0;
    case (t)
      TGT_RAM: o = OFF_W'(a[RAM_AW-1:0]);
      TGT_REG: o = OFF_W'(a[REG_AW-1:0]);
      TGT_ROM: o = big ? a[ROM_AW-1:0] : OFF_W'(a[ROM_SMALL_AW-1:0]);
      default: o = '0;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/mm_region_dec.sv
module mm_region_dec
  import mm_pkg::*;
(
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output mm_tgt_e           tgt
);
  always_comb begin
    tgt = req ? region_of(addr) : TGT_NONE;
  end
endmodule

// File: rtl/mm_fold.sv
module mm_fold
  import mm_pkg::*;
(
  input  mm_tgt_e           tgt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rom_big,
  output logic [OFF_W-1:0]  off
);
  always_comb begin
    off = fold_off(tgt, addr, rom_big);
  end
endmodule

// File: rtl/mm_rd_mux.sv
module mm_rd_mux
  import mm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  mm_tgt_e           tgt,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [DATA_W-1:0] rd_data
);
  mm_tgt_e tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= TGT_NONE;
    else        tgt_q <= capture ? tgt : TGT_NONE;
  end

  always_comb begin
    case (tgt_q)
      TGT_RAM: rd_data = ram_rdata;
      TGT_REG: rd_data = reg_rdata;
      TGT_ROM: rd_data = rom_rdata;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mirror_map_dec.sv
module mirror_map_dec
  import mm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rom_big,
  output logic              ram_sel,
  output logic              reg_sel,
  output logic              rom_sel,
  output logic              ram_we,
  output logic              reg_we,
  output logic [OFF_W-1:0]  phys_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [DATA_W-1:0] rd_data
);
  localparam int N_TGT = 3;

  mm_tgt_e          tgt;
  logic [N_TGT-1:0] sel_vec;
  logic             rd_cap;

  mm_region_dec u_dec (
    .req  (req),
    .addr (addr),
    .tgt  (tgt)
  );

  mm_fold u_fold (
    .tgt     (tgt),
    .addr    (addr),
    .rom_big (rom_big),
    .off     (phys_addr)
  );

  for (genvar i = 0; i < N_TGT; i++) begin : g_sel
    assign sel_vec[i] = (tgt == mm_tgt_e'(2'(i + 1)));
  end

  assign ram_sel = sel_vec[0];
  assign reg_sel = sel_vec[1];
  assign rom_sel = sel_vec[2];
  // ROM has no write enable, so writes decoded there are dropped.
  assign ram_we  = sel_vec[0] & wr;
  assign reg_we  = sel_vec[1] & wr;
  assign rd_cap  = req & ~wr;

  mm_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rd_cap),
    .tgt       (tgt),
    .ram_rdata (ram_rdata),
    .reg_rdata (reg_rdata),
    .rom_rdata (rom_rdata),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/mm_checker.sv
module mm_checker
  import mm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic              ram_sel,
  input logic              reg_sel,
  input logic              rom_sel,
  input logic              ram_we,
  input logic              reg_we,
  input logic [OFF_W-1:0]  phys_addr,
  input logic [DATA_W-1:0] ram_rdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] rom_rdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_cap
);
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, reg_sel, rom_sel}));

  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !(ram_sel || reg_sel || rom_sel || ram_we || reg_we));

  a_r1_ram_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr < 16'h2000) |-> (ram_sel && phys_addr == {4'd0, addr[10:0]}));

  a_r7_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr >= 16'h4000 && addr < 16'h8000) |-> (!ram_sel && !reg_sel && !rom_sel && phys_addr == '0));

  a_r6_rom_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && wr) |-> (!ram_we && !reg_we));

  a_r9_ram_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cap && ram_sel) |=> (rd_data == ram_rdata));

  a_r9_rom_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cap && rom_sel) |=> (rd_data == rom_rdata));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || wr) |=> (rd_data == '0));
endmodule

bind mirror_map_dec mm_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mirror_map_dec.sv
module tb_mirror_map_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, rom_big = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ram_sel, reg_sel, rom_sel, ram_we, reg_we;
  logic [14:0] phys_addr;
  logic [7:0]  ram_q = '0, reg_q = '0, rom_q = '0, rd_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ram_m [2048];
  logic [7:0] reg_m [8];
  logic [7:0] sh_ram [2048];
  logic [7:0] sh_reg [8];

  always #2 clk = ~clk;

  mirror_map_dec dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .rom_big(rom_big),
    .ram_sel(ram_sel), .reg_sel(reg_sel), .rom_sel(rom_sel),
    .ram_we(ram_we), .reg_we(reg_we), .phys_addr(phys_addr),
    .ram_rdata(ram_q), .reg_rdata(reg_q), .rom_rdata(rom_q), .rd_data(rd_data)
  );

  function automatic logic [7:0] rom_byte(input logic [14:0] o);
    return o[7:0] ^ {1'b0, o[14:8]} ^ 8'h5A;
  endfunction

  // Target models: synchronous, one cycle read latency.
  always @(posedge clk) begin
    if (ram_we) ram_m[phys_addr[10:0]] <= wdata;
    if (ram_sel && !wr) ram_q <= ram_m[phys_addr[10:0]];
    if (reg_we) reg_m[phys_addr[2:0]] <= wdata;
    if (reg_sel && !wr) reg_q <= reg_m[phys_addr[2:0]];
    if (rom_sel && !wr) rom_q <= rom_byte(phys_addr);
  end

  // Bench view of the map: 0 none, 1 RAM, 2 registers, 3 ROM.
  function automatic int exp_tgt(input logic [15:0] a);
    if (a < 16'h2000) return 1;
    if (a < 16'h4000) return 2;
    if (a < 16'h8000) return 0;
    return 3;
  endfunction

  function automatic int exp_off(input logic [15:0] a, input logic big);
    int t;
    t = exp_tgt(a);
    if (t == 1) return int'(a) % 2048;
    if (t == 2) return (int'(a) - 8192) % 8;
    if (t == 3) return big ? int'(a) - 32768 : (int'(a) - 32768) % 16384;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic w, input logic [15:0] a,
                        input logic big, input logic [7:0] d);
    int t, o;
    logic [7:0] e;
    @(negedge clk);
    req = r; wr = w; addr = a; rom_big = big; wdata = d;
    t = r ? exp_tgt(a) : 0;
    o = (t != 0) ? exp_off(a, big) : 0;
    #1;
    if (!r) begin
      chk(!(ram_sel || reg_sel || rom_sel || ram_we || reg_we), "R8 idle selects", 1, 0);
    end else begin
      chk({ram_sel, reg_sel, rom_sel} == {t == 1, t == 2, t == 3},
          (t == 1) ? "R1 select" : (t == 2) ? "R2 select" : (t == 3) ? "R3 select" : "R7 select",
          int'({ram_sel, reg_sel, rom_sel}), int'({t == 1, t == 2, t == 3}));
      chk(int'(phys_addr) == o,
          (t == 3 && !big) ? "R4 offset" : (t == 0) ? "R7 offset" : "R1/R2/R3 offset",
          int'(phys_addr), o);
      chk(ram_we == (w && t == 1) && reg_we == (w && t == 2),
          (t == 3) ? "R6 no enable" : "R5 enable", int'({ram_we, reg_we}),
          int'({w && t == 1, w && t == 2}));
    end
    e = 8'h00;
    if (r && !w) begin
      if (t == 1) e = sh_ram[o];
      else if (t == 2) e = sh_reg[o];
      else if (t == 3) e = rom_byte(15'(o));
    end
    @(posedge clk);
    #1;
    chk(rd_data == e, (r && !w) ? ((t == 0) ? "R7 read zero" : "R9 read data") : "R9 quiet zero",
        int'(rd_data), int'(e));
    if (r && w && t == 1) sh_ram[o] = d;
    if (r && w && t == 2) sh_reg[o] = d;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] ra;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) begin
      ram_m[i] = 8'(i * 7 + 3);
      sh_ram[i] = 8'(i * 7 + 3);
    end
    for (int i = 0; i < 8; i++) begin
      reg_m[i] = 8'(8'hA0 + i);
      sh_reg[i] = 8'(8'hA0 + i);
    end
    repeat (3) @(posedge clk);
    #1;
    chk(rd_data == 8'h00, "R10 reset value", int'(rd_data), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(rd_data == 8'h00, "R10 after reset", int'(rd_data), 0);

    // Directed corners
    access(1, 0, 16'h0000, 1, 0);
    access(1, 0, 16'h07FF, 1, 0);
    access(1, 1, 16'h0805, 1, 8'hC3);   // R5 write through mirror 1
    access(1, 0, 16'h1805, 1, 0);       // read back through mirror 3
    access(1, 0, 16'h0005, 1, 0);
    access(1, 0, 16'h1FFF, 1, 0);
    access(1, 0, 16'h2000, 1, 0);
    access(1, 1, 16'h3FFA, 1, 8'h3C);   // R5 register write via last mirror
    access(1, 0, 16'h2002, 1, 0);
    access(1, 0, 16'h200F, 1, 0);
    access(1, 0, 16'h4000, 1, 0);       // R7 hole edges
    access(1, 0, 16'h7FFF, 0, 0);
    access(1, 1, 16'h5000, 1, 8'h11);
    access(1, 0, 16'h8000, 1, 0);       // R3
    access(1, 0, 16'hFFFF, 1, 0);
    access(1, 0, 16'hC123, 0, 0);       // R4 high mirror
    access(1, 0, 16'h8123, 0, 0);
    access(1, 0, 16'hBFFF, 0, 0);
    access(1, 1, 16'h9000, 1, 8'hEE);   // R6 ROM write dropped
    access(1, 0, 16'h9000, 1, 0);
    access(0, 0, 16'h0001, 1, 0);       // R8 idle
    access(0, 1, 16'h8001, 1, 8'h55);

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 4)
        0: ra = 16'($urandom % 16'h2000);
        1: ra = 16'h2000 + 16'($urandom % 16'h2000);
        2: ra = 16'h8000 + 16'($urandom % 16'h8000);
        default: ra = 16'($urandom);
      endcase
      access(($urandom % 8) != 0, ($urandom % 3) == 0, ra, 1'($urandom), 8'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule